// File: doc/BRIEF.md
# Split-FIFO Sender Credit Tracker

This block is the transmit half of a FIFO whose storage sits in a neighbouring block. The local logic presents a load strobe with a data word. When the remote FIFO has room, the load and the word leave through output flops toward the far side. The block holds none of the data itself. Instead it keeps a count of the entries it believes the remote FIFO holds. An accepted load raises that count, and each extract pulse that the receiver sends back lowers it.

The count drives two plain comparators. The first raises `full_o` when every remote entry is in use. The second raises `afull_o` once the free space has fallen to `AF_DEPTH` entries or fewer, which gives upstream stages time to stop. Every signal that crosses the boundary is registered on both sides, so the extract and init returns pass through capture flops here before they act.

An init pulse from the receiver clears the count and blocks loads for that cycle. This keeps both halves empty together when their resets release at different times. A returned extract that arrives while the count is zero indicates a protocol fault, and it is reported on `err_o`. The parameter `ASYNC_RST` selects an asynchronous or a synchronous reset.

Top module: `sndf_tx`

## Requirements
- R1: While `rst_ni` is low, `load_o`, `full_o`, `afull_o` and `err_o` are 0, `data_o` is 0, and the count is zero.
- R2: A load that is accepted appears on `load_o` one clock edge later, with `data_o` holding the `data_i` value of the accepting cycle. `data_o` keeps its value while no load is forwarded.
- R3: While `full_o` is 1, a load is dropped (no `load_o`, no count change). The exception is a cycle in which the captured extract is 1: then the load is accepted.
- R4: `full_o` is 1 exactly when the count equals `DEPTH`.
- R5: `afull_o` is 1 exactly when `DEPTH - count <= AF_DEPTH`.
- R6: `ext_ret_i` is captured on one edge and lowers the count on the following edge. Its effect on `full_o` and `afull_o` therefore shows two edges after it is driven.
- R7: When an accepted load and a captured extract with a nonzero count meet in the same cycle, the count is unchanged.
- R8: `init_ret_i` is captured on one edge. While the captured init is 1, the next edge sets the count to zero, and any load in that cycle is dropped.
- R9: `err_o` is 1 while the captured extract is 1 and the count is zero. Such an extract leaves the count at zero, so it never wraps.
- R10: With `ASYNC_RST=1`, driving `rst_ni` low in mid-operation clears the outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| load_i | input | 1 | Local load request |
| data_i | input | WIDTH | Local data word |
| ext_ret_i | input | 1 | Extract pulse returned by the receiver |
| init_ret_i | input | 1 | Init pulse returned by the receiver |
| load_o | output | 1 | Registered load strobe to the receiver |
| data_o | output | WIDTH | Registered data word to the receiver |
| full_o | output | 1 | Remote FIFO is full |
| afull_o | output | 1 | Free remote entries are at or below AF_DEPTH |
| err_o | output | 1 | Extract returned while the count is zero |

## Verification
The assertions check the following on every cycle:
- the count never exceeds `DEPTH`;
- a full cycle without a captured extract forwards no load;
- an accepted load reaches `load_o` and `data_o` on the next edge;
- `full_o` implies `afull_o`;
- the cycle after a captured init leaves the count at zero;
- an extract at a zero count does not wrap the count.

Only the bench scenarios can show the following:
- the exact thresholds of `full_o` and `afull_o`;
- the two-edge delay of a returned extract;
- the extract that lets a load in while full;
- the error flag;
- the asynchronous clear.

// File: rtl/sndf_pkg.sv
package sndf_pkg;
  typedef enum logic [1:0] {
    OCC_HOLD = 2'd0,
    OCC_INC  = 2'd1,
    OCC_DEC  = 2'd2,
    OCC_CLR  = 2'd3
  } occ_op_e;
endpackage

// File: rtl/sndf_reg.sv
module sndf_reg #(
  parameter int unsigned W     = 1,
  parameter bit          ASYNC = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  if (ASYNC) begin : g_async
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)   q <= '0;
      else if (en_i) q <= d_i;
  end else begin : g_sync
    always_ff @(posedge clk_i)
      if (!rst_ni)   q <= '0;
      else if (en_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/sndf_occ.sv
module sndf_occ
  import sndf_pkg::*;
#(
  parameter int unsigned DEPTH    = 10,
  parameter int unsigned AF_DEPTH = 2,
  parameter bit          ASYNC    = 1'b1,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic ext_i,
  input  logic clr_i,
  output logic full_o,
  output logic afull_o,
  output logic err_o
);
  logic [CW-1:0] cnt, cnt_d, free;
  occ_op_e       op;
  logic          dec;

  assign dec = ext_i && (cnt != '0);

  always_comb begin
    if (clr_i)             op = OCC_CLR;
    else if (inc_i && !dec) op = OCC_INC;
    else if (dec && !inc_i) op = OCC_DEC;
    else                   op = OCC_HOLD;
  end

  always_comb begin
    unique case (op)
      OCC_INC: cnt_d = cnt + 1'b1;
      OCC_DEC: cnt_d = cnt - 1'b1;
      OCC_CLR: cnt_d = '0;
      default: cnt_d = cnt;
    endcase
  end

  sndf_reg #(.W(CW), .ASYNC(ASYNC)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1), .d_i(cnt_d), .q_o(cnt)
  );

  assign free    = CW'(DEPTH) - cnt;
  assign full_o  = (cnt == CW'(DEPTH));
  assign afull_o = (free <= CW'(AF_DEPTH));
  assign err_o   = ext_i && (cnt == '0);

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  a_r8_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt == '0));
  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !inc_i) |=> (cnt == '0));
  a_r5_full_afull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> afull_o);
endmodule

// File: rtl/sndf_tx.sv
module sndf_tx #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned DEPTH    = 10,
  parameter int unsigned AF_DEPTH = 2,
  parameter bit          ASYNC_RST = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             ext_ret_i,
  input  logic             init_ret_i,
  output logic             load_o,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             afull_o,
  output logic             err_o
);
  logic [1:0] ret_q;
  logic       ext_q, init_q, accept;

  // boundary capture of returned handshakes
  sndf_reg #(.W(2), .ASYNC(ASYNC_RST)) u_ret (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1),
    .d_i({init_ret_i, ext_ret_i}), .q_o(ret_q)
  );
  assign ext_q  = ret_q[0];
  assign init_q = ret_q[1];

  // a captured extract frees a slot this same cycle
  assign accept = load_i && !init_q && (!full_o || ext_q);

  sndf_reg #(.W(1), .ASYNC(ASYNC_RST)) u_ld (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1), .d_i(accept), .q_o(load_o)
  );
  sndf_reg #(.W(WIDTH), .ASYNC(ASYNC_RST)) u_dat (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(accept), .d_i(data_i), .q_o(data_o)
  );

  sndf_occ #(.DEPTH(DEPTH), .AF_DEPTH(AF_DEPTH), .ASYNC(ASYNC_RST)) u_occ (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(accept), .ext_i(ext_q),
    .clr_i(init_q), .full_o(full_o), .afull_o(afull_o), .err_o(err_o)
  );

  a_r3_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !ext_q) |=> !load_o);
  a_r2_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !full_o && !init_q) |=> (load_o && data_o == $past(data_i)));
endmodule

// File: tb/sim_sndf_tx.sv
module sim_sndf_tx;
  localparam int D  = 6;
  localparam int AF = 2;
  localparam int NV = 21;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       load = 1'b0, ext = 1'b0, init = 1'b0;
  logic [7:0] din = '0;
  logic       load_o, full_o, afull_o, err_o;
  logic [7:0] data_o;

  int checks = 0, errors = 0;
  int m_cnt = 0;
  bit m_ext = 0, m_init = 0, m_ld = 0;
  logic [7:0] m_dat = '0;

  always #2 clk = ~clk;

  sndf_tx #(.WIDTH(8), .DEPTH(D), .AF_DEPTH(AF), .ASYNC_RST(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .data_i(din),
    .ext_ret_i(ext), .init_ret_i(init), .load_o(load_o), .data_o(data_o),
    .full_o(full_o), .afull_o(afull_o), .err_o(err_o)
  );

  // {load, ext, init, data}
  localparam logic [10:0] VEC [NV] = '{
    {3'b100, 8'h11}, {3'b100, 8'h22}, // R2 forward
    {3'b000, 8'h33},                  // R2 data holds
    {3'b100, 8'h44}, {3'b100, 8'h55}, // R5 afull at 4
    {3'b100, 8'h66}, {3'b100, 8'h77}, // R4 full at 6
    {3'b100, 8'h88},                  // R3 dropped
    {3'b110, 8'h99},                  // R6 extract only captured
    {3'b100, 8'hAA},                  // R3 R7 load in while full
    {3'b010, 8'hBB}, {3'b010, 8'hCC}, {3'b010, 8'hDD},
    {3'b000, 8'hEE},                  // R5 afull drops
    {3'b110, 8'hF0}, {3'b100, 8'hF1}, // R7 inc and dec cancel
    {3'b011, 8'hF2},                  // R8 init captured
    {3'b100, 8'hF3},                  // R8 load dropped, clear
    {3'b010, 8'hF4}, {3'b100, 8'hF5}, // R9 extract at zero
    {3'b000, 8'hF6}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 load_o", 8'(load_o), 8'(m_ld));
    chk("R2 data_o", data_o, m_dat);
    chk("R4 full_o", 8'(full_o), 8'(m_cnt == D));
    chk("R5 afull_o", 8'(afull_o), 8'((D - m_cnt) <= AF));
    chk("R9 err_o", 8'(err_o), 8'(m_ext && m_cnt == 0));
  endtask

  task automatic step(input logic l, input logic e, input logic i, input logic [7:0] d);
    bit acc, dec;
    load = l; ext = e; init = i; din = d;
    @(posedge clk);
    acc = l && !m_init && (m_cnt < D || m_ext);
    dec = m_ext && m_cnt != 0;
    if (m_init) m_cnt = 0;
    else m_cnt = m_cnt + int'(acc) - int'(dec);
    m_ld = acc;
    if (acc) m_dat = d;
    m_ext = e; m_init = i;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++)
      step(VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7:0]);
    // R10 async clear mid-operation
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0, 8'(8'h30 + k));
    #1 rst_n = 1'b0;
    #0.5;
    m_cnt = 0; m_ext = 0; m_init = 0; m_ld = 0; m_dat = '0;
    chk("R10 load_o", 8'(load_o), 8'h0);
    chk("R10 afull_o", 8'(afull_o), 8'h0);
    chk("R10 data_o", data_o, 8'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, 8'h5A);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule